// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Drive Latch

This block takes a serial bit stream and presents it as a parallel word of on/off drive bits. Bits enter a shift register on the rising edge of a shift clock. A separate latch clock copies the whole shift word into a holding register in one step. An enable gate then passes the held word to the drive outputs. A drive bit of 1 turns its load switch on, and a drive bit of 0 turns it off.

Several instances can be chained. The cascade output of one stage feeds the serial input of the next, and all stages share the shift and latch clocks. The cascade output is re-timed on the falling shift-clock edge. A downstream stage therefore samples a value that has been stable for half a clock period, which gives margin against skew between stages. A single active-low clear empties the shift register, the holding register and the cascade flop. A disabled output is driven to the off level and is never left floating.

Top module: `sipo_drive_latch`

## Requirements
- R1: While `clear_n` is low, `drive` is all zeros and `cascade_out` is 0, whatever `oe_n` is. The clear acts at once and does not wait for any clock edge.
- R2: On each rising edge of `shift_clk` with `clear_n` high, `ser_in` enters bit 0 of the shift word and every bit n moves to bit n+1. Bit 0 of the held word drives `drive[0]`.
- R3: `drive` changes only on a rising edge of `latch_clk`, when the held word takes the current shift word. Shifting without a latch-clock edge leaves `drive` unchanged.
- R4: The clear also empties the held word. After a clear, with `oe_n` low, `drive` reads zero until the next latch-clock edge. This holds even if a latch-clock edge occurs while the clear is low.
- R5: While `oe_n` is high, every `drive` bit is 0. The held word is kept, and it reappears when `oe_n` returns low.
- R6: While `oe_n` is low, `drive` follows the held word without a clock. This includes the case where the enable falls in the same shift-clock low phase as a latch-clock edge.
- R7: `cascade_out` is the top bit of the shift word as it stood at the last falling edge of `shift_clk`. Between a rising edge and the next falling edge it keeps its old value.
- R8: Two stages are chained through `cascade_out`. A 16-bit word is pushed in most significant bit first, and one latch-clock edge follows. The downstream stage then drives bits 15..8 of the word and the upstream stage drives bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data, sampled on the rising edge of the shift clock |
| shift_clk | input | 1 | Shift clock |
| latch_clk | input | 1 | Latch clock; its rising edge loads the held word |
| clear_n | input | 1 | Asynchronous active-low clear of all registers |
| oe_n | input | 1 | Active-low enable; when high, all drive bits are forced off |
| drive | output | WIDTH | Gated held word, where 1 means the switch is on |
| cascade_out | output | 1 | Top shift bit, re-timed on the falling shift-clock edge |

## Verification
Three functions can meet in the same shift-clock low phase: the latch capture, the release of the output enable, and the clear. The bench provokes the first pair by dropping `oe_n` in the same low phase as a latch-clock pulse, and expects the new word on `drive` before the next rising edge. It provokes the second pair by raising the latch clock while the clear is held low, and expects `drive` to read zero afterwards. Random shifting, latching, enabling and occasional clears are checked throughout against a two-stage reference model kept in the bench.

// File: rtl/sipo_drive_pkg.sv
`timescale 1ns/1ps
package sipo_drive_pkg;

   // Default number of drive bits per stage.
   localparam int unsigned DEF_WIDTH = 8;

   // How the cascade output is timed relative to the shift clock.
   typedef enum logic {
      CASC_FALL = 1'b0,   // re-timed on the falling edge (hold margin)
      CASC_RISE = 1'b1    // raw top bit, changes with the rising edge
   } casc_mode_e;

endpackage

// File: rtl/sipo_shift_stage.sv
`timescale 1ns/1ps
module sipo_shift_stage
   import sipo_drive_pkg::*;
#(
   parameter int unsigned WIDTH     = DEF_WIDTH,
   parameter casc_mode_e  CASC_MODE = CASC_FALL
) (
   input  logic             shift_clk,
   input  logic             clear_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] shift_q,
   output logic             cascade_out
);

   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_chk
      $error("sipo_shift_stage: WIDTH must be at least 2");
   end

   // Serial entry at bit 0, ripple towards the top bit.
   always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) shift_q <= '0;
      else          shift_q <= {shift_q[TOP-1:0], ser_in};
   end

   AST_SHIFT_ENTRY: assert property (@(posedge shift_clk) disable iff (!clear_n)
      1'b1 |=> (shift_q[0] == $past(ser_in)));                               // R2

   AST_SHIFT_RIPPLE: assert property (@(posedge shift_clk) disable iff (!clear_n)
      1'b1 |=> (shift_q[TOP:1] == $past(shift_q[TOP-1:0])));                 // R2

   if (CASC_MODE == CASC_FALL) begin : g_casc_fall
      logic casc_q;

      always_ff @(negedge shift_clk or negedge clear_n) begin
         if (!clear_n) casc_q <= 1'b0;
         else          casc_q <= shift_q[TOP];
      end
      assign cascade_out = casc_q;

      // At every rising edge the cascade still shows the top bit left by the
      // previous rising edge, captured at the falling edge in between.
      AST_CASCADE_TRAIL: assert property (@(posedge shift_clk) disable iff (!clear_n)
         cascade_out == shift_q[TOP]);                                       // R7
   end else begin : g_casc_rise
      assign cascade_out = shift_q[TOP];
   end

endmodule

// File: rtl/sipo_hold_reg.sv
`timescale 1ns/1ps
module sipo_hold_reg
   import sipo_drive_pkg::*;
#(
   parameter int unsigned WIDTH = DEF_WIDTH
) (
   input  logic             latch_clk,
   input  logic             clear_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_width_chk
      $error("sipo_hold_reg: WIDTH must be at least 1");
   end

   // Word-wide capture; the clear reaches this register too.
   always_ff @(posedge latch_clk or negedge clear_n) begin
      if (!clear_n) q <= '0;
      else          q <= d;
   end

endmodule

// File: rtl/sipo_drive_gate.sv
`timescale 1ns/1ps
module sipo_drive_gate
   import sipo_drive_pkg::*;
#(
   parameter int unsigned WIDTH = DEF_WIDTH
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] hold_q,
   output logic [WIDTH-1:0] drive
);

   // Each bit is forced to the off level while disabled; never floating.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign drive[i] = hold_q[i] & ~oe_n;
   end

endmodule

// File: rtl/sipo_drive_latch.sv
`timescale 1ns/1ps
module sipo_drive_latch
   import sipo_drive_pkg::*;
#(
   parameter int unsigned WIDTH     = DEF_WIDTH,
   parameter casc_mode_e  CASC_MODE = CASC_FALL
) (
   input  logic             ser_in,
   input  logic             shift_clk,
   input  logic             latch_clk,
   input  logic             clear_n,
   input  logic             oe_n,
   output logic [WIDTH-1:0] drive,
   output logic             cascade_out
);

   if (WIDTH < 2) begin : g_width_chk
      $error("sipo_drive_latch: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] shift_w;
   logic [WIDTH-1:0] hold_w;

   sipo_shift_stage #(
      .WIDTH     (WIDTH),
      .CASC_MODE (CASC_MODE)
   ) u_shift (
      .shift_clk   (shift_clk),
      .clear_n     (clear_n),
      .ser_in      (ser_in),
      .shift_q     (shift_w),
      .cascade_out (cascade_out)
   );

   sipo_hold_reg #(
      .WIDTH (WIDTH)
   ) u_hold (
      .latch_clk (latch_clk),
      .clear_n   (clear_n),
      .d         (shift_w),
      .q         (hold_w)
   );

   sipo_drive_gate #(
      .WIDTH (WIDTH)
   ) u_gate (
      .oe_n   (oe_n),
      .hold_q (hold_w),
      .drive  (drive)
   );

   AST_OFF_FORCES_LOW: assert property (@(posedge shift_clk) disable iff (!clear_n)
      oe_n |-> (drive == '0));                                               // R5

   AST_ON_SHOWS_HOLD: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !oe_n |-> (drive == hold_w));                                          // R6

endmodule

// File: tb/sipo_drive_latch_bench.sv
`timescale 1ns/1ps
module sipo_drive_latch_bench;

   localparam int W  = 8;
   localparam int W2 = 2 * W;

   logic shift_clk = 1'b0;
   logic latch_clk = 1'b0;
   logic clear_n   = 1'b1;
   logic oe_n      = 1'b1;
   logic ser_in    = 1'b0;

   logic [W-1:0] drv_up, drv_dn;
   logic         casc_up, casc_dn;

   always #2.5 shift_clk = ~shift_clk;   // 200 MHz

   sipo_drive_latch #(.WIDTH(W)) u_sipo_drive_latch (
      .ser_in (ser_in), .shift_clk (shift_clk), .latch_clk (latch_clk),
      .clear_n (clear_n), .oe_n (oe_n), .drive (drv_up), .cascade_out (casc_up)
   );

   sipo_drive_latch #(.WIDTH(W)) u_sipo_drive_latch_down (
      .ser_in (casc_up), .shift_clk (shift_clk), .latch_clk (latch_clk),
      .clear_n (clear_n), .oe_n (oe_n), .drive (drv_dn), .cascade_out (casc_dn)
   );

   int checks = 0;
   int errors = 0;

   // Reference of the two-stage chain: bit 0 newest, bits 15..8 downstream.
   logic [W2-1:0] ref_sh, ref_hold;
   logic          ref_cu, ref_cd;

   always @(posedge shift_clk or negedge clear_n)
      if (!clear_n) ref_sh <= '0;
      else          ref_sh <= {ref_sh[W2-2:0], ser_in};

   always @(negedge shift_clk or negedge clear_n)
      if (!clear_n) begin ref_cu <= 1'b0; ref_cd <= 1'b0; end
      else begin ref_cu <= ref_sh[W-1]; ref_cd <= ref_sh[W2-1]; end

   always @(posedge latch_clk or negedge clear_n)
      if (!clear_n) ref_hold <= '0;
      else          ref_hold <= ref_sh;

   function automatic logic [W-1:0] exp_drive(logic off, logic [W-1:0] held);
      return off ? '0 : held;
   endfunction

   task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
      end
   endtask

   task automatic model_checks();
      chk("R6 upstream drive",   16'(drv_up), 16'(exp_drive(oe_n, ref_hold[W-1:0])));
      chk("R8 downstream drive", 16'(drv_dn), 16'(exp_drive(oe_n, ref_hold[W2-1:W])));
      chk("R7 upstream cascade",   16'(casc_up), 16'(ref_cu));
      chk("R7 downstream cascade", 16'(casc_dn), 16'(ref_cd));
   endtask

   // One shift-clock period: set inputs after the falling edge, optionally
   // pulse the latch clock in the low phase, check, then check the cascade
   // just after the rising edge (it must not have moved yet).
   task automatic step(logic b, logic do_latch, logic off);
      @(negedge shift_clk);
      #0.5 ser_in = b; oe_n = off;
      if (do_latch) begin
         #0.5 latch_clk = 1'b1;
         #0.8 latch_clk = 1'b0;
         #0.2;
      end else begin
         #1.5;
      end
      model_checks();
      @(posedge shift_clk);
      #1;
      chk("R7 cascade held past rising edge", 16'(casc_up), 16'(ref_cu));
   endtask

   // Clear held low across one rising edge; a latch pulse lands inside it.
   task automatic pulse_clear(logic latch_inside);
      @(negedge shift_clk);
      #0.3 clear_n = 1'b0;
      #0.3 chk("R1 drive cleared at once", 16'(drv_up), 16'h0000);
      if (latch_inside) begin
         #0.4 latch_clk = 1'b1;
         #0.8 latch_clk = 1'b0;
      end
      @(negedge shift_clk);
      #0.3 clear_n = 1'b1;
   endtask

   logic [15:0] word;

   initial begin
      void'($urandom(32'd7319));
      #1 clear_n = 1'b0;
      oe_n = 1'b0;
      #12;
      chk("R1 reset drive up",   16'(drv_up),  16'h0000);
      chk("R1 reset drive down", 16'(drv_dn),  16'h0000);
      chk("R1 reset cascade",    16'(casc_up), 16'h0000);
      @(negedge shift_clk);
      #0.3 clear_n = 1'b1;

      // R2: walking one, latched after every shift
      step(1'b1, 1'b0, 1'b0);
      for (int k = 0; k < W; k++) begin
         step(1'b0, 1'b1, 1'b0);
         chk("R2 walking one upstream", 16'(drv_up), 16'(1 << k));
      end
      step(1'b0, 1'b1, 1'b0);
      chk("R8 one crossed into downstream", 16'(drv_dn), 16'h0001);

      // R8: 16-bit word, MSB first, then one latch
      word = 16'hA5C3;
      for (int i = W2 - 1; i >= 0; i--) step(word[i], 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      chk("R8 upstream byte",   16'(drv_up), 16'(word[7:0]));
      chk("R8 downstream byte", 16'(drv_dn), 16'(word[15:8]));

      // R3: more shifts without latch leave drive alone
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
      chk("R3 drive frozen without latch", 16'(drv_up), 16'(word[7:0]));

      // R5: disable forces off, held word comes back
      step(1'b0, 1'b0, 1'b1);
      chk("R5 disabled drive off", 16'(drv_up), 16'h0000);
      step(1'b0, 1'b0, 1'b0);
      chk("R5 held word restored", 16'(drv_up), 16'(word[7:0]));

      // R6: enable released in the same low phase as a latch
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b0);
      chk("R6 new word on enable+latch", 16'(drv_up), 16'(ref_hold[W-1:0]));

      // R4: clear empties the held word, even with a latch during the clear
      pulse_clear(1'b1);
      #1;
      chk("R4 hold emptied by clear", 16'(drv_up), 16'h0000);
      chk("R4 downstream emptied",    16'(drv_dn), 16'h0000);
      chk("R1 cascade emptied",       16'(casc_dn), 16'h0000);

      // Random mix
      for (int n = 0; n < 400; n++) begin
         if (($urandom % 40) == 0) pulse_clear(1'($urandom % 2));
         else step(1'($urandom % 2), 1'(($urandom % 4) == 0), 1'(($urandom % 5) == 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule